// File: doc/BRIEF.md
# Montgomery Ladder Scalar Multiplication Controller

This block sequences a scalar multiplication kP on a binary elliptic curve over GF(2^283) with the Montgomery ladder. It takes a scalar, the affine x of the base point and the curve constant b. From these it builds two projective points in (X, Z) form: X1 = x, Z1 = 1, Z2 = x^2 and X2 = x^4 + b. It uses one shared field squarer for this, over two cycles. It then walks the scalar from the bit just below its leading one down to bit 0. For every bit it hands one combined add-and-double step to an external point datapath, waits for that datapath to finish, and writes the two results back into the point registers. The current key bit picks which register pair gets the sum and which gets the double.

Each step always does one addition and one doubling, whatever the key bit is. The bit only swaps the operand and result routing, so the step sequence and its cycle cost do not depend on the key's bit values. When the last step completes, the four coordinates stay on the outputs with `done` high until the next start. A scalar of zero has no leading one. It ends in an error state and no step is issued. Conversion back to affine coordinates is left to the surrounding system.

States: `LS_IDLE` (after reset), `LS_INIT_SQ` (capture X1, Z1, Z2 and the leading-one index), `LS_INIT_QD` (form X2 from the squarer), `LS_ISSUE` (one-cycle step request), `LS_WAIT` (hold operands until the datapath finishes), `LS_DONE` and `LS_ERR`. Transitions:
- `LS_IDLE`, `LS_DONE` and `LS_ERR` go to `LS_INIT_SQ` on start.
- `LS_INIT_SQ` goes to `LS_INIT_QD` for a nonzero scalar, or to `LS_ERR` for a zero scalar.
- `LS_INIT_QD` goes to `LS_DONE` when no bit lies below the leading one, and to `LS_ISSUE` otherwise.
- `LS_ISSUE` always goes to `LS_WAIT`.
- `LS_WAIT` stays put until `step_done`. It then goes to `LS_ISSUE` if bits remain, or to `LS_DONE` after bit 0.

Top module: `mont_ladder_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `err` and `step_req` are all 0.
- R2: A zero scalar drives `err` to 1 with `done` at 0 and issues no step request. `err` stays high until the next start.
- R3: The starting coordinates are X1 = x, Z1 = 1, Z2 = x^2 and X2 = x^4 + b. Field arithmetic is modulo z^283 + z^12 + z^7 + z^5 + 1. With scalar 1 these values appear unchanged on the result outputs.
- R4: A run issues exactly L-1 steps, where L is the bit position of the scalar's leading one plus one. Steps go from bit L-2 down to bit 0, and zero bits above the leading one have no effect.
- R5: For key bit 1, the destination operands are (X1,Z1), the other operands are (X2,Z2), the sum is written to (X1,Z1) and the double to (X2,Z2). For key bit 0 the two pairs swap roles in all four places.
- R6: `step_req` is a one-cycle pulse. No new request is issued until `step_done` has been seen, and every operand output stays stable while the controller waits.
- R7: At the end of a run, `q_x1`, `q_z1`, `q_x2` and `q_z2` equal the Montgomery ladder result. `done` then stays high and the outputs stay unchanged until the next start.
- R8: A start pulse while `busy` is high is ignored, and the inputs are captured only when a run is accepted.
- R9: For a fixed datapath latency, two scalars with the same leading-one position take the same number of cycles from start to `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when not busy |
| scalar | input | N | Scalar k, captured on accepted start |
| base_x | input | M | Affine x of the base point |
| curve_b | input | M | Curve constant b |
| busy | output | 1 | Run in progress |
| done | output | 1 | Result valid; held until next start |
| err | output | 1 | Zero scalar seen; held until next start |
| step_req | output | 1 | One-cycle request for an add-and-double step |
| op_dst_x | output | M | X of the pair that receives the sum |
| op_dst_z | output | M | Z of the pair that receives the sum |
| op_oth_x | output | M | X of the other pair (also the doubling input) |
| op_oth_z | output | M | Z of the other pair (also the doubling input) |
| op_base_x | output | M | Captured affine x for the addition formula |
| op_curve_b | output | M | Captured b for the doubling formula |
| step_done | input | 1 | Datapath finished the requested step (one-cycle pulse) |
| sum_x | input | M | X of the point sum |
| sum_z | input | M | Z of the point sum |
| dbl_x | input | M | X of the doubled point |
| dbl_z | input | M | Z of the doubled point |
| q_x1 | output | M | Final X1 |
| q_z1 | output | M | Final Z1 |
| q_x2 | output | M | Final X2 |
| q_z2 | output | M | Final Z2 |

## Verification
The in-RTL properties check the handshake on every cycle:
- the request is a single-cycle pulse;
- the operands hold still while a step is outstanding;
- the step index stays in range;
- `done` and `err` never coexist, and both persist until a start;
- a zero scalar lands in the error state;
- a start during a run leaves the captured scalar alone.

Only the bench scenarios can show the arithmetic outcome. The bench models the point datapath with real field formulas and compares the routed operands of every step against a reference ladder. It also confirms the initial coordinate values, the step count per scalar length and the equal timing of same-length keys.

// File: rtl/mlad_pkg.sv
package mlad_pkg;

    localparam int FIELD_M  = 283;
    localparam int KEY_BITS = 283;
    // reduction polynomial without its top term: z^12 + z^7 + z^5 + 1
    localparam logic [FIELD_M-1:0] FIELD_POLY_LOW = FIELD_M'(13'h10A1);

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_INIT_SQ,
        LS_INIT_QD,
        LS_ISSUE,
        LS_WAIT,
        LS_DONE,
        LS_ERR
    } lad_state_t;

endpackage

// File: rtl/gf2m_square.sv
module gf2m_square #(
    parameter int              M        = 283,
    parameter logic [M-1:0]    POLY_LOW = M'(13'h10A1)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int WW = 2 * M - 1;

    function automatic logic [M-1:0] square_reduce(input logic [M-1:0] v);
        logic [WW-1:0] w;
        w = '0;
        // squaring in characteristic two just spreads the bits apart
        for (int i = 0; i < M; i++) begin
            w[2*i] = v[i];
        end
        // fold every high term down, highest first
        for (int i = WW - 1; i >= M; i--) begin
            if (w[i]) begin
                w[i-M +: M] = w[i-M +: M] ^ POLY_LOW;
            end
        end
        return w[M-1:0];
    endfunction

    always_comb begin
        y = square_reduce(a);
    end

endmodule

// File: rtl/lead_one_find.sv
module lead_one_find #(
    parameter int N  = 283,
    parameter int IW = 9
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] pos,
    output logic          any
);
    always_comb begin
        pos = '0;
        any = |vec;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                pos = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ladder_route.sv
module ladder_route #(
    parameter int M = 283
) (
    input  logic         key_bit,
    input  logic [M-1:0] p1x,
    input  logic [M-1:0] p1z,
    input  logic [M-1:0] p2x,
    input  logic [M-1:0] p2z,
    output logic [M-1:0] dst_x,
    output logic [M-1:0] dst_z,
    output logic [M-1:0] oth_x,
    output logic [M-1:0] oth_z,
    input  logic [M-1:0] sum_x,
    input  logic [M-1:0] sum_z,
    input  logic [M-1:0] dbl_x,
    input  logic [M-1:0] dbl_z,
    output logic [M-1:0] n1x,
    output logic [M-1:0] n1z,
    output logic [M-1:0] n2x,
    output logic [M-1:0] n2z
);
    // key bit 1: sum lands in pair 1, double in pair 2; bit 0 mirrors it
    always_comb begin
        if (key_bit) begin
            dst_x = p1x;  dst_z = p1z;
            oth_x = p2x;  oth_z = p2z;
            n1x   = sum_x; n1z  = sum_z;
            n2x   = dbl_x; n2z  = dbl_z;
        end else begin
            dst_x = p2x;  dst_z = p2z;
            oth_x = p1x;  oth_z = p1z;
            n1x   = dbl_x; n1z  = dbl_z;
            n2x   = sum_x; n2z  = sum_z;
        end
    end

endmodule

// File: rtl/mont_ladder_ctrl.sv
module mont_ladder_ctrl
    import mlad_pkg::*;
#(
    parameter int           M        = FIELD_M,
    parameter int           N        = KEY_BITS,
    parameter logic [M-1:0] POLY_LOW = M'(FIELD_POLY_LOW)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] scalar,
    input  logic [M-1:0] base_x,
    input  logic [M-1:0] curve_b,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic         step_req,
    output logic [M-1:0] op_dst_x,
    output logic [M-1:0] op_dst_z,
    output logic [M-1:0] op_oth_x,
    output logic [M-1:0] op_oth_z,
    output logic [M-1:0] op_base_x,
    output logic [M-1:0] op_curve_b,
    input  logic         step_done,
    input  logic [M-1:0] sum_x,
    input  logic [M-1:0] sum_z,
    input  logic [M-1:0] dbl_x,
    input  logic [M-1:0] dbl_z,
    output logic [M-1:0] q_x1,
    output logic [M-1:0] q_z1,
    output logic [M-1:0] q_x2,
    output logic [M-1:0] q_z2
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    lad_state_t     state_q, state_d;
    logic [N-1:0]   k_q;
    logic [M-1:0]   bx_q, cb_q;
    logic [M-1:0]   x1_q, z1_q, x2_q, z2_q;
    logic [IW-1:0]  idx_q;

    logic [IW-1:0]  lead_pos;
    logic           lead_any;
    logic [M-1:0]   sq_in, sq_out;
    logic           cur_bit;
    logic           accept;
    logic           last_bit;
    logic [M-1:0]   n1x, n1z, n2x, n2z;

    // ---------------- submodules ----------------
    lead_one_find #(.N(N), .IW(IW)) u_lead (
        .vec (k_q),
        .pos (lead_pos),
        .any (lead_any)
    );

    // one squarer shared: x^2 first, then (x^2)^2
    assign sq_in = (state_q == LS_INIT_SQ) ? bx_q : z2_q;

    gf2m_square #(.M(M), .POLY_LOW(POLY_LOW)) u_sq (
        .a (sq_in),
        .y (sq_out)
    );

    assign cur_bit  = k_q[idx_q];
    assign last_bit = (idx_q == '0);

    ladder_route #(.M(M)) u_route (
        .key_bit (cur_bit),
        .p1x     (x1_q),
        .p1z     (z1_q),
        .p2x     (x2_q),
        .p2z     (z2_q),
        .dst_x   (op_dst_x),
        .dst_z   (op_dst_z),
        .oth_x   (op_oth_x),
        .oth_z   (op_oth_z),
        .sum_x   (sum_x),
        .sum_z   (sum_z),
        .dbl_x   (dbl_x),
        .dbl_z   (dbl_z),
        .n1x     (n1x),
        .n1z     (n1z),
        .n2x     (n2x),
        .n2z     (n2z)
    );

    assign accept = start && (state_q == LS_IDLE || state_q == LS_DONE ||
                              state_q == LS_ERR);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE, LS_DONE, LS_ERR: if (start) state_d = LS_INIT_SQ;
            LS_INIT_SQ:               state_d = lead_any ? LS_INIT_QD : LS_ERR;
            LS_INIT_QD:               state_d = last_bit ? LS_DONE : LS_ISSUE;
            LS_ISSUE:                 state_d = LS_WAIT;
            LS_WAIT: begin
                if (step_done) state_d = last_bit ? LS_DONE : LS_ISSUE;
            end
            default:                  state_d = LS_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- point and capture registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q   <= '0;
            bx_q  <= '0;
            cb_q  <= '0;
            x1_q  <= '0;
            z1_q  <= '0;
            x2_q  <= '0;
            z2_q  <= '0;
            idx_q <= '0;
        end else begin
            if (accept) begin
                k_q  <= scalar;
                bx_q <= base_x;
                cb_q <= curve_b;
            end
            unique case (state_q)
                LS_INIT_SQ: begin
                    x1_q  <= bx_q;
                    z1_q  <= M'(1);
                    z2_q  <= sq_out;
                    idx_q <= lead_pos;
                end
                LS_INIT_QD: begin
                    x2_q <= sq_out ^ cb_q;
                    if (!last_bit) idx_q <= idx_q - 1'b1;
                end
                LS_WAIT: begin
                    if (step_done) begin
                        x1_q <= n1x;
                        z1_q <= n1z;
                        x2_q <= n2x;
                        z2_q <= n2z;
                        if (!last_bit) idx_q <= idx_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        step_req = 1'b0;
        unique case (state_q)
            LS_INIT_SQ, LS_INIT_QD, LS_WAIT: busy = 1'b1;
            LS_ISSUE: begin
                busy     = 1'b1;
                step_req = 1'b1;
            end
            LS_DONE: done = 1'b1;
            LS_ERR:  err  = 1'b1;
            default: ;
        endcase
    end

    assign op_base_x  = bx_q;
    assign op_curve_b = cb_q;
    assign q_x1 = x1_q;
    assign q_z1 = z1_q;
    assign q_x2 = x2_q;
    assign q_z2 = z2_q;

    // ---------------- assertions ----------------
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !err && !step_req));

    // R6
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |=> !step_req);

    // R6
    opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_WAIT && !step_done) |=>
        ($stable(op_dst_x) && $stable(op_dst_z) && $stable(op_oth_x) &&
         $stable(op_oth_z) && $stable(op_base_x) && $stable(op_curve_b)));

    // R2
    zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_INIT_SQ && k_q == '0) |=> (err && !step_req && !done));

    // R2 R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=>
        (done && $stable(q_x1) && $stable(q_z1) && $stable(q_x2) && $stable(q_z2)));

    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(k_q));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(idx_q) < N));

endmodule

// File: tb/mont_ladder_ctrl_tb.sv
module mont_ladder_ctrl_tb;
    localparam int M   = 283;
    localparam int N   = 283;
    localparam int LAT = 3;
    localparam logic [M:0] FPOLY = ((M+1)'(1) << M) | (M+1)'(13'h10A1);

    typedef struct packed {
        logic [M-1:0] a;
        logic [M-1:0] b;
        logic [M-1:0] c;
        logic [M-1:0] d;
    } quad_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] scalar = '0;
    logic [M-1:0] base_x = '0, curve_b = '0;
    logic         busy, done, err, step_req;
    logic [M-1:0] op_dst_x, op_dst_z, op_oth_x, op_oth_z, op_base_x, op_curve_b;
    logic         step_done = 1'b0;
    logic [M-1:0] sum_x = '0, sum_z = '0, dbl_x = '0, dbl_z = '0;
    logic [M-1:0] q_x1, q_z1, q_x2, q_z2;

    int n_chk = 0, n_fail = 0, steps_seen = 0;
    quad_t exp_step[$];
    quad_t exp_res[$];
    quad_t last_res;
    logic  done_d = 1'b0;

    always #2 clk = ~clk;

    mont_ladder_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
        .base_x(base_x), .curve_b(curve_b), .busy(busy), .done(done), .err(err),
        .step_req(step_req), .op_dst_x(op_dst_x), .op_dst_z(op_dst_z),
        .op_oth_x(op_oth_x), .op_oth_z(op_oth_z), .op_base_x(op_base_x),
        .op_curve_b(op_curve_b), .step_done(step_done), .sum_x(sum_x),
        .sum_z(sum_z), .dbl_x(dbl_x), .dbl_z(dbl_z),
        .q_x1(q_x1), .q_z1(q_z1), .q_x2(q_x2), .q_z2(q_z2)
    );

    // ---------------- field reference ----------------
    function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M:0] r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = {r[M-1:0], 1'b0};
            if (r[M]) r = r ^ FPOLY;
            if (b[i]) r[M-1:0] = r[M-1:0] ^ a;
        end
        return r[M-1:0];
    endfunction

    function automatic logic [M-1:0] gsq(input logic [M-1:0] a);
        return gmul(a, a);
    endfunction

    function automatic logic [M-1:0] pattern(input int seed);
        logic [M-1:0] v = '0;
        int unsigned s = 32'(seed) * 32'd2654435761 + 32'd12345;
        for (int i = 0; i < M; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            v[i] = s[16];
        end
        return v;
    endfunction

    // sum of two ladder points (dst first), then double of a point
    function automatic logic [2*M-1:0] padd(input logic [M-1:0] xa, za, xb, zb, bx);
        logic [M-1:0] t1, t2, z3, x3;
        t1 = gmul(xa, zb);
        t2 = gmul(xb, za);
        z3 = gsq(t1 ^ t2);
        x3 = gmul(bx, z3) ^ gmul(t1, t2);
        return {x3, z3};
    endfunction

    function automatic logic [2*M-1:0] pdbl(input logic [M-1:0] xa, za, cb);
        logic [M-1:0] x2s, z2s;
        x2s = gsq(xa);
        z2s = gsq(za);
        return {gsq(x2s) ^ gmul(cb, gsq(z2s)), gmul(x2s, z2s)};
    endfunction

    // ---------------- scoreboard driver side ----------------
    task automatic ref_ladder(input logic [N-1:0] k, input logic [M-1:0] x, input logic [M-1:0] b);
        logic [M-1:0] X1, Z1, X2, Z2;
        logic [2*M-1:0] s, d;
        int lead = -1;
        for (int i = 0; i < N; i++) if (k[i]) lead = i;
        if (lead < 0) return;
        X1 = x; Z1 = M'(1); Z2 = gsq(x); X2 = gsq(Z2) ^ b;
        for (int i = lead - 1; i >= 0; i--) begin
            if (k[i]) begin
                exp_step.push_back('{X1, Z1, X2, Z2});
                s = padd(X1, Z1, X2, Z2, x);
                d = pdbl(X2, Z2, b);
                {X1, Z1} = s; {X2, Z2} = d;
            end else begin
                exp_step.push_back('{X2, Z2, X1, Z1});
                s = padd(X2, Z2, X1, Z1, x);
                d = pdbl(X1, Z1, b);
                {X2, Z2} = s; {X1, Z1} = d;
            end
        end
        exp_res.push_back('{X1, Z1, X2, Z2});
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [M-1:0] act, input logic [M-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic run_case(input logic [N-1:0] k, input logic [M-1:0] x,
                            input logic [M-1:0] b, output int cyc);
        ref_ladder(k, x, b);
        @(negedge clk);
        scalar = k; base_x = x; curve_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!(done || err)) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    // ---------------- datapath model and step monitor (R5, R6) ----------------
    initial begin
        quad_t e;
        logic [2*M-1:0] s, d;
        forever begin
            @(negedge clk);
            step_done = 1'b0;
            if (rst_n && step_req) begin
                steps_seen++;
                if (exp_step.size() == 0) begin
                    check(1'b0, "R4", "unexpected step request", '0, '0);
                end else begin
                    e = exp_step.pop_front();
                    check(op_dst_x == e.a && op_dst_z == e.b, "R5", "dst operands",
                          op_dst_x ^ op_dst_z, e.a ^ e.b);
                    check(op_oth_x == e.c && op_oth_z == e.d, "R5", "other operands",
                          op_oth_x ^ op_oth_z, e.c ^ e.d);
                end
                s = padd(op_dst_x, op_dst_z, op_oth_x, op_oth_z, op_base_x);
                d = pdbl(op_oth_x, op_oth_z, op_curve_b);
                repeat (LAT) begin
                    @(negedge clk);
                    check(!step_req, "R6", "request repeated before step_done",
                          M'(step_req), '0);
                end
                {sum_x, sum_z} = s;
                {dbl_x, dbl_z} = d;
                step_done = 1'b1;
            end
        end
    end

    // ---------------- result monitor (R7) ----------------
    always @(negedge clk) begin
        quad_t e;
        if (rst_n && done && !done_d) begin
            if (exp_res.size() == 0) begin
                check(1'b0, "R7", "unexpected done", '0, '0);
            end else begin
                e = exp_res.pop_front();
                last_res = e;
                check(q_x1 == e.a, "R7", "q_x1", q_x1, e.a);
                check(q_z1 == e.b, "R7", "q_z1", q_z1, e.b);
                check(q_x2 == e.c, "R7", "q_x2", q_x2, e.c);
                check(q_z2 == e.d, "R7", "q_z2", q_z2, e.d);
            end
        end
        done_d = done;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        int c0, c1, c2, s0;
        logic [N-1:0] klong;
        logic [M-1:0] xa, xb;
        xa = pattern(1);
        xb = pattern(7);

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !step_req, "R1", "flags in reset",
              M'({busy, done, err, step_req}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !step_req, "R1", "flags after reset",
              M'({busy, done, err, step_req}), '0);

        // R3 scalar 1: initial coordinates unchanged, no steps
        s0 = steps_seen;
        run_case(N'(1), xa, M'(1), c0);
        check(steps_seen == s0, "R3", "no steps for scalar 1", M'(steps_seen - s0), '0);
        check(q_x1 == xa && q_z1 == M'(1), "R3", "X1/Z1 init", q_x1, xa);
        check(q_z2 == gsq(xa), "R3", "Z2 = x^2", q_z2, gsq(xa));
        check(q_x2 == (gsq(gsq(xa)) ^ M'(1)), "R3", "X2 = x^4 + b", q_x2, gsq(gsq(xa)) ^ M'(1));

        // R7 hold after done
        repeat (6) @(negedge clk);
        check(done && q_x2 == last_res.c && q_z2 == last_res.d, "R7", "hold after done",
              q_x2, last_res.c);

        // R2 zero scalar
        s0 = steps_seen;
        run_case('0, xb, M'(1), c0);
        check(err && !done, "R2", "error flag", M'({err, done}), M'(2'b10));
        check(steps_seen == s0, "R2", "no steps for zero", M'(steps_seen - s0), '0);
        repeat (5) @(negedge clk);
        check(err && !busy, "R2", "error held", M'({err, busy}), M'(2'b10));

        // R4 R5 short scalars of both bit values
        s0 = steps_seen;
        run_case(N'(2), xb, pattern(3), c0);
        check(steps_seen - s0 == 1, "R4", "steps for k=2", M'(steps_seen - s0), M'(1));
        s0 = steps_seen;
        run_case(N'(3), xa, pattern(4), c0);
        check(steps_seen - s0 == 1, "R4", "steps for k=3", M'(steps_seen - s0), M'(1));

        // R9 equal timing for equal length, different bits
        s0 = steps_seen;
        run_case(N'(16'hA5C3), xa, M'(1), c1);
        check(steps_seen - s0 == 15, "R4", "steps for 16-bit scalar", M'(steps_seen - s0), M'(15));
        run_case(N'(16'h8000), xb, pattern(5), c2);
        check(c1 == c2, "R9", "same-length cycle count", M'(c1), M'(c2));
        run_case(N'(16'hFFFF), xa, pattern(6), c2);
        check(c1 == c2, "R9", "same-length cycle count all ones", M'(c2), M'(c1));

        // R8 full-length scalar with a start pulse mid-run
        klong = '0;
        for (int i = 0; i < N; i++) klong[i] = ((i * 7 + 3) % 5) < 2;
        klong[N-1] = 1'b1;
        s0 = steps_seen;
        fork
            run_case(klong, xb, M'(1), c0);
            begin
                repeat (60) @(negedge clk);
                scalar = N'(1); base_x = xa;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(steps_seen - s0 == N - 1, "R8", "mid-run start ignored, step count",
              M'(steps_seen - s0), M'(N - 1));
        check(exp_res.size() == 0 && exp_step.size() == 0, "R7", "scoreboard drained",
              M'(exp_res.size() + exp_step.size()), '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule